// File: doc/BRIEF.md
# Page Write Buffer and Timed Write Sequencer

This block sits behind the serial command front end of a non-volatile byte memory. When a write-to-array command opens, it takes the start address, then gathers each incoming data byte into a one-page staging buffer. Only the low offset bits of the address advance per byte, so a long burst wraps and rewrites earlier slots of the same page. A mask records which slots received data.

The front end signals deselection and says whether it fell on a byte boundary. On an aligned deselect with at least one byte staged, the block starts a self-timed internal cycle. The cycle first clears every staged byte location to the erased value 0x00, in ascending offset order, and then programs the staged values in the same order. Busy stays high for a fixed, parameterised number of clock cycles, which models the multi-millisecond write time. When busy falls, a one-cycle done pulse follows, which the front end uses to drop its write-enable latch. The array itself is a plain RAM that is driven through a write request port.

Top module: `pwe_top`

## Requirements
- R1: After reset, busy_o, done_o and arr_we_o are all 0.
- R2: A write cycle starts only when term_i is high with term_aligned_i high, busy_o is 0, a command is open and at least one byte has been staged. busy_o then reads 1 from the next cycle.
- R3: A term_i with term_aligned_i low discards the staged bytes. No array write and no busy follow.
- R4: busy_o stays high for exactly CYCLE_LEN consecutive cycles. done_o is high for exactly one cycle, namely the first cycle in which busy_o reads 0, and at no other time.
- R5: In the erase phase, each staged offset gets one array write with data 0x00, in ascending offset order. All erase writes come before any program write.
- R6: In the program phase, each staged offset gets one array write carrying its staged byte, in ascending offset order.
- R7: Array writes occur only while busy_o is 1 and only at staged offsets. Each write address is {cmd_addr_i[ADDR_W-1:PAGE_W], offset}, so slots that were not staged keep their contents.
- R8: Bytes are staged starting at offset cmd_addr_i[PAGE_W-1:0]. The offset increments by one per byte and wraps from 2**PAGE_W-1 to 0.
- R9: When a slot is loaded more than once because of wrap, only the last byte loaded into it is programmed.
- R10: While busy_o is 1, cmd_start_i, byte_vld_i and term_i have no effect: no new cycle starts and no extra writes occur.
- R11: A byte_vld_i received while no command is open (before any cmd_start_i, or after a term_i) is not staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Opens a write command and samples cmd_addr_i |
| cmd_addr_i | input | ADDR_W | Start byte address of the command |
| byte_vld_i | input | 1 | One complete data byte is present |
| byte_i | input | 8 | Data byte |
| term_i | input | 1 | Device deselected (command ends) |
| term_aligned_i | input | 1 | The deselect fell on a byte boundary |
| arr_we_o | output | 1 | Array write request |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_wdata_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write cycle in progress |
| done_o | output | 1 | One-cycle pulse at the end of the cycle |

## Verification
The bench keeps the 15-bit address and the full 64-byte page. It shortens CYCLE_LEN to 200 cycles, so that several complete write cycles fit in one run while still leaving a hold window after the 128-cycle erase and program walk. That window gives room to inject commands, bytes and deselects while the cycle is busy. With the real page size, bursts of 70 bytes and starts near the page end reach the wrap and the double-load cases.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ERASE = 2'd1,
    SQ_PROG  = 2'd2,
    SQ_HOLD  = 2'd3
  } seq_state_e;

  localparam logic [7:0] ERASED_BYTE = 8'h00;
endpackage

// File: rtl/pwe_page_buf.sv
module pwe_page_buf #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     release_i,
  input  logic                     cmd_start_i,
  input  logic [ADDR_W-1:0]        cmd_addr_i,
  input  logic                     byte_vld_i,
  input  logic [7:0]               byte_i,
  input  logic                     term_i,
  input  logic                     keep_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [7:0]               rd_data_o,
  output logic                     rd_loaded_o,
  output logic [(1<<PAGE_W)-1:0]   mask_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic                     open_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [7:0]        slot_q [PAGE];
  logic [PAGE-1:0]   mask_q, mask_d;
  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic              open_q, open_d;
  logic              take_cmd, take_byte, take_term;

  assign take_cmd  = cmd_start_i & ~busy_i;
  assign take_byte = byte_vld_i & open_q & ~busy_i & ~cmd_start_i;
  assign take_term = term_i & ~busy_i;

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    page_d = page_q;
    open_d = open_q;
    if (release_i) mask_d = '0;
    if (take_cmd) begin
      mask_d = '0;
      ptr_d  = cmd_addr_i[PAGE_W-1:0];
      page_d = cmd_addr_i[ADDR_W-1:PAGE_W];
      open_d = 1'b1;
    end else if (take_byte) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;
    end else if (take_term) begin
      open_d = 1'b0;
      if (!keep_i) mask_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      page_q <= '0;
      open_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      page_q <= page_d;
      open_q <= open_d;
    end
  end

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (take_byte && (ptr_q == g[PAGE_W-1:0])) slot_q[g] <= byte_i;
      end
    end
  endgenerate

  assign rd_data_o   = slot_q[rd_idx_i];
  assign rd_loaded_o = mask_q[rd_idx_i];
  assign mask_o      = mask_q;
  assign page_o      = page_q;
  assign open_o      = open_q;

  // R10
  mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && $past(busy_i) |-> $stable(mask_q));
endmodule

// File: rtl/pwe_seq.sv
module pwe_seq #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int CYCLE_LEN = 500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [7:0]               rd_data_i,
  input  logic                     rd_loaded_i,
  output logic [PAGE_W-1:0]        rd_idx_o,
  output logic                     arr_we_o,
  output logic [ADDR_W-1:0]        arr_addr_o,
  output logic [7:0]               arr_wdata_o,
  output logic                     busy_o,
  output logic                     done_o
);
  import pwe_pkg::*;

  localparam int TMR_W = $clog2(CYCLE_LEN + 1);
  localparam logic [PAGE_W-1:0] LAST_IDX = {PAGE_W{1'b1}};
  localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(CYCLE_LEN - 1);

  seq_state_e        st_q, st_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic              done_q, done_d;
  logic              walking;

  assign walking = (st_q == SQ_ERASE) || (st_q == SQ_PROG);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    tmr_d  = tmr_q;
    done_d = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d  = SQ_ERASE;
          idx_d = '0;
          tmr_d = '0;
        end
      end
      SQ_ERASE: begin
        tmr_d = tmr_q + 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = SQ_PROG;
      end
      SQ_PROG: begin
        tmr_d = tmr_q + 1'b1;
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) st_d = SQ_HOLD;
      end
      SQ_HOLD: begin
        tmr_d = tmr_q + 1'b1;
        if (tmr_q == TMR_END) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      idx_q  <= '0;
      tmr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      tmr_q  <= tmr_d;
      done_q <= done_d;
    end
  end

  assign rd_idx_o    = idx_q;
  assign arr_we_o    = walking & rd_loaded_i;
  assign arr_addr_o  = {page_i, idx_q};
  assign arr_wdata_o = (st_q == SQ_ERASE) ? ERASED_BYTE : rd_data_i;
  assign busy_o      = (st_q != SQ_IDLE);
  assign done_o      = done_q;

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o));
  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> tmr_q < TMR_W'(CYCLE_LEN));
endmodule

// File: rtl/pwe_top.sv
module pwe_top #(
  parameter int ADDR_W    = 15,
  parameter int PAGE_W    = 6,
  parameter int CYCLE_LEN = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              term_i,
  input  logic              term_aligned_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] rd_idx;
  logic [7:0]        rd_data;
  logic              rd_loaded;
  logic [PAGE-1:0]   ld_mask;
  logic [PG_W-1:0]   page;
  logic              open;
  logic              start_ok;

  assign start_ok = term_i & term_aligned_i & ~busy_o & open & (|ld_mask);

  pwe_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_o),
    .release_i   (done_o),
    .cmd_start_i (cmd_start_i),
    .cmd_addr_i  (cmd_addr_i),
    .byte_vld_i  (byte_vld_i),
    .byte_i      (byte_i),
    .term_i      (term_i),
    .keep_i      (start_ok),
    .rd_idx_i    (rd_idx),
    .rd_data_o   (rd_data),
    .rd_loaded_o (rd_loaded),
    .mask_o      (ld_mask),
    .page_o      (page),
    .open_o      (open)
  );

  pwe_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_LEN(CYCLE_LEN)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_ok),
    .page_i      (page),
    .rd_data_i   (rd_data),
    .rd_loaded_i (rd_loaded),
    .rd_idx_o    (rd_idx),
    .arr_we_o    (arr_we_o),
    .arr_addr_o  (arr_addr_o),
    .arr_wdata_o (arr_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  // R7
  staged_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o && ld_mask[arr_addr_o[PAGE_W-1:0]]);
  // R3
  no_start_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_i && !term_aligned_i && !busy_o |=> !busy_o);
endmodule

// File: tb/test_pwe_top.sv
module test_pwe_top;
  localparam int ADDR_W = 15;
  localparam int PAGE_W = 6;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int CYC    = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_d = '0;
  logic term = 1'b0;
  logic term_al = 1'b0;
  logic arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_wdata;
  logic busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [ADDR_W+7:0] expq [$];

  always #5 clk = ~clk;

  pwe_top #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_LEN(CYC)) i_pwe_top (
    .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start), .cmd_addr_i(cmd_addr),
    .byte_vld_i(byte_vld), .byte_i(byte_d), .term_i(term),
    .term_aligned_i(term_al), .arr_we_o(arr_we), .arr_addr_o(arr_addr),
    .arr_wdata_o(arr_wdata), .busy_o(busy), .done_o(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: array writes against the scoreboard, busy length and done pulse
  int  bcnt = 0;
  bit  pbusy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (arr_we) begin
        if (expq.size() == 0) chk(1'b0, "R7 unexpected write", {arr_addr, arr_wdata}, 0);
        else begin
          logic [ADDR_W+7:0] e;
          e = expq.pop_front();
          // R5 R6 R9 order, address and data of each array write
          chk({arr_addr, arr_wdata} == e, "R5/R6 write item", {arr_addr, arr_wdata}, e);
        end
      end
      if (busy) bcnt++;
      else if (pbusy) begin
        chk(bcnt == CYC, "R4 busy length", bcnt, CYC);
        chk(done == 1'b1, "R4 done at busy fall", done, 1);
        bcnt = 0;
      end else if (done) chk(1'b0, "R4 stray done", done, 0);
      pbusy = busy;
    end
  end

  // Driver: runs one command and pushes the expected array writes
  task automatic run_cmd(input int addr, input int n, input int seed,
                         input bit aligned, input bit expect_start);
    bit [7:0] md [PAGE];
    bit       mm [PAGE];
    int       base, pg;
    for (int k = 0; k < PAGE; k++) begin mm[k] = 0; md[k] = 0; end
    base = addr % PAGE;
    pg   = addr / PAGE;
    @(negedge clk); cmd_start = 1'b1; cmd_addr = ADDR_W'(addr);
    @(negedge clk); cmd_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_d = 8'((seed + i * 37) & 8'hff);
      mm[(base + i) % PAGE] = 1;                 // R8 wrap within page
      md[(base + i) % PAGE] = 8'((seed + i * 37) & 8'hff);  // R9 last wins
      @(negedge clk);
    end
    byte_vld = 1'b0;
    if (expect_start) begin
      for (int k = 0; k < PAGE; k++) if (mm[k]) expq.push_back({ADDR_W'(pg * PAGE + k), 8'h00});
      for (int k = 0; k < PAGE; k++) if (mm[k]) expq.push_back({ADDR_W'(pg * PAGE + k), md[k]});
    end
    term = 1'b1; term_al = aligned;
    @(negedge clk); term = 1'b0; term_al = 1'b0;
  endtask

  task automatic finish_cycle(input string req);
    chk(busy == 1'b1, "R2 busy after aligned term", busy, 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic expect_quiet(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy || arr_we) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && arr_we == 0, "R1 reset outputs", {busy, done, arr_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1 idle after reset", busy, 0);

    // R2 R5 R6 single byte
    run_cmd('h1234, 1, 'h5a, 1'b1, 1'b1);
    finish_cycle("R6 single byte all writes seen");

    // R8 start near page end, wraps to offset 0
    run_cmd('h2bbe, 5, 'h11, 1'b1, 1'b1);
    finish_cycle("R8 wrap writes seen");

    // R9 burst longer than a page, double loads
    run_cmd('h00ca, 70, 'h03, 1'b1, 1'b1);
    finish_cycle("R9 overwrite writes seen");

    // R3 unaligned deselect
    run_cmd('h0400, 4, 'h77, 1'b0, 1'b0);
    expect_quiet("R3 no cycle on unaligned term");
    // R3 discarded bytes do not resurface on a later empty command
    run_cmd('h0400, 0, 0, 1'b1, 1'b0);
    expect_quiet("R3 discarded bytes stay discarded");

    // R2 no bytes staged: no start
    run_cmd('h7000, 0, 0, 1'b1, 1'b0);
    expect_quiet("R2 no start without bytes");

    // R10 activity during busy is ignored
    run_cmd('h3010, 3, 'h90, 1'b1, 1'b1);
    chk(busy == 1'b1, "R10 cycle running", busy, 1);
    repeat (140) @(negedge clk);
    cmd_start = 1'b1; cmd_addr = 'h0100;
    @(negedge clk); cmd_start = 1'b0;
    for (int i = 0; i < 5; i++) begin byte_vld = 1'b1; byte_d = 8'(i); @(negedge clk); end
    byte_vld = 1'b0; term = 1'b1; term_al = 1'b1;
    @(negedge clk); term = 1'b0; term_al = 1'b0;
    finish_cycle("R10 only the first command written");
    term = 1'b1; term_al = 1'b1;
    @(negedge clk); term = 1'b0; term_al = 1'b0;
    expect_quiet("R10 no late start");

    // R11 bytes with no open command
    for (int i = 0; i < 3; i++) begin byte_vld = 1'b1; byte_d = 8'hc0; @(negedge clk); end
    byte_vld = 1'b0; term = 1'b1; term_al = 1'b1;
    @(negedge clk); term = 1'b0; term_al = 1'b0;
    expect_quiet("R11 stray bytes not staged");

    // R7 a further multi-byte command, after all the quiet cases
    run_cmd('h5555, 9, 'he1, 1'b1, 1'b1);
    finish_cycle("R7 writes confined to staged slots");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule